// File: doc/BRIEF.md
# Switched State-Machine Bank

This block holds several small table-driven state machines that share one input alphabet and one set of state codes. A select value names the active machine. Control inputs reach only that machine, and the block feeds back the active machine's present state together with its index. The alphabet has two parts: normal inputs, which a controller applies, and adversarial inputs, which a test or fault source injects to force an unauthorised move. Each machine's next-state table and a shared switching table are filled through plain write ports. A cleared valid bit marks an entry as undefined.

The bank is modelled synchronously, and each clock performs one transient micro-step. After a new input, the active machine looks up its table once per cycle and moves to the next state. It stops when the entry returns the state it already holds. The stable flag is low for the whole chain and rises only when the chain has settled. The bank works in fundamental mode: a command is accepted only while the flag is high, and only one command may arrive in a cycle. A switch moves the bank into the target machine at a state given by the switching table. The switch is admitted only when the present control input is normal and is also stable for that target state in the target machine.

There is no streaming data path. Every pin is a plain control or status signal, so the block has no back-pressure rule. A rejected command is dropped and reported with a one-cycle pulse and a reason code.

Top module: `ssm_bank`

## Requirements
- R1: After reset every machine is at state 0, machine 0 is active, the present input is code 0, `stable_o` is high, and all pulse outputs are low. Reset also clears every valid bit in the next-state and switching tables.
- R2: An input accepted at a clock edge drops `stable_o` after that edge. On each following edge the active machine moves to the next state in its table, and `state_o` shows every intermediate state. On the first edge where the entry equals the current state, `stable_o` rises again. A chain of k moves therefore keeps `stable_o` low for k+1 cycles.
- R3: An input, injection or select command that arrives while `stable_o` is low is dropped. The cycle after, `rej_o` pulses with `rej_why_o` = 0. The running chain and the held input are unchanged.
- R4: When more than one of `in_we`, `adv_we` and `sel_we` is high in the same cycle, none of them takes effect. `rej_o` pulses with `rej_why_o` = 1. This reason takes precedence over reason 0.
- R5: A normal input code of NNORM or more, an adversarial code of NADV or more, or a select of M or more is dropped. `rej_o` pulses with `rej_why_o` = 2.
- R6: A select of machine j, issued while machine i is active at state p, reads the switching entry (i, p, j). The switch is admitted when that entry is valid with target state q, the held input u is a normal code, and machine j's entry (q, u) is valid and equals q. When admitted, `active_o` = j and `state_o` = q one cycle later, and `stable_o` stays high.
- R7: A select that fails any condition in R6 is dropped. `rej_o` pulses with `rej_why_o` = 3, and the active index and state are unchanged.
- R8: Adversarial code k is applied as alphabet column NNORM+k and runs a chain like R2. While that column is held, every switch is refused. A normal input applied afterwards allows switching again.
- R9: When a lookup hits an entry whose valid bit is clear, the state does not change. `flt_undef_o` pulses in the same cycle that `stable_o` rises.
- R10: If the N-th lookup of a chain is still transient (N-1 moves already made), the machine stops without moving. `flt_cycle_o` pulses as `stable_o` rises.
- R11: Selecting the machine that is already active is accepted without rejection and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each edge is one micro-step |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Write one next-state table entry |
| tbl_mach | input | MW | Machine whose table is written |
| tbl_state | input | SW | Present-state row of the entry |
| tbl_in | input | IW | Alphabet column (adversarial k at NNORM+k) |
| tbl_next | input | SW | Next state stored in the entry |
| tbl_ok | input | 1 | Valid bit of the entry |
| sw_we | input | 1 | Write one switching table entry |
| sw_src_mach | input | MW | Machine switched from |
| sw_src_state | input | SW | State held when switching |
| sw_dst_mach | input | MW | Machine switched to |
| sw_dst_state | input | SW | Landing state in the target machine |
| sw_ok | input | 1 | Valid bit of the switching entry |
| in_we | input | 1 | Apply a normal input |
| in_code | input | IW | Normal input code |
| adv_we | input | 1 | Inject an adversarial input |
| adv_code | input | IW | Adversarial input index |
| sel_we | input | 1 | Request a machine switch |
| sel_code | input | MW | Machine to activate |
| state_o | output | SW | Present state of the active machine |
| active_o | output | MW | Index of the active machine |
| stable_o | output | 1 | Active machine has settled |
| rej_o | output | 1 | One-cycle pulse: command dropped |
| rej_why_o | output | 2 | Reason: 0 busy, 1 collision, 2 range, 3 switch refused |
| flt_undef_o | output | 1 | One-cycle pulse: undefined entry reached |
| flt_cycle_o | output | 1 | One-cycle pulse: chain exceeded the step limit |

## Verification
The tables are built so that chains of one, two and three moves occur, and each settle time is compared with the move count. Switches are attempted three ways: with the landing entry stable (admitted), with it transient (refused), and with an adversarial column held (refused, then admitted after a normal input). Separate patterns hit an undefined entry and a two-state loop, which tells the two fault pulses apart. A command issued in the middle of a chain is checked against the unchanged final state. Simultaneous commands and out-of-range codes are checked for the right reason code with no change of state.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    REJ_BUSY  = 2'd0,
    REJ_MULTI = 2'd1,
    REJ_RANGE = 2'd2,
    REJ_DENY  = 2'd3
  } rej_e;
endpackage

// File: rtl/ssm_machine.sv
module ssm_machine #(
  parameter int N   = 4,
  parameter int NIN = 5,
  parameter int SW  = 2,
  parameter int IW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_state,
  input  logic [IW-1:0] wr_in,
  input  logic [SW-1:0] wr_next,
  input  logic          wr_ok,
  input  logic          go,
  input  logic [IW-1:0] go_in,
  input  logic          load,
  input  logic [SW-1:0] load_state,
  input  logic [SW-1:0] rd_state,
  input  logic [IW-1:0] rd_in,
  output logic          rd_ok,
  output logic [SW-1:0] rd_next,
  output logic [SW-1:0] state_o,
  output logic          busy_o,
  output logic          undef_o,
  output logic          cycle_o
);
  localparam logic [SW-1:0] LAST_STEP = SW'(N - 1);

  logic          ent_ok [N][NIN];
  logic [SW-1:0] ent_nx [N][NIN];

  logic [SW-1:0] st, steps;
  logic [IW-1:0] inp;
  logic          busy, undef_q, cyc_q;
  logic          cur_ok;
  logic [SW-1:0] cur_nx;

  // table storage, one row per state, one column per alphabet symbol
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < N; s++) begin
        for (int i = 0; i < NIN; i++) begin
          ent_ok[s][i] <= 1'b0;
          ent_nx[s][i] <= '0;
        end
      end
    end else if (wr_en && int'(wr_state) < N && int'(wr_in) < NIN && int'(wr_next) < N) begin
      ent_ok[wr_state][wr_in] <= wr_ok;
      ent_nx[wr_state][wr_in] <= wr_next;
    end
  end

  assign cur_ok  = ent_ok[st][inp];
  assign cur_nx  = ent_nx[st][inp];
  assign rd_ok   = ent_ok[rd_state][rd_in];
  assign rd_next = ent_nx[rd_state][rd_in];

  // micro-step engine: one lookup per clock while busy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= '0;
      inp     <= '0;
      busy    <= 1'b0;
      steps   <= '0;
      undef_q <= 1'b0;
      cyc_q   <= 1'b0;
    end else begin
      undef_q <= 1'b0;
      cyc_q   <= 1'b0;
      if (go) begin
        inp   <= go_in;
        busy  <= 1'b1;
        steps <= '0;
      end else if (load) begin
        st   <= load_state;
        inp  <= go_in;
        busy <= 1'b0;
      end else if (busy) begin
        if (!cur_ok) begin
          busy    <= 1'b0;
          undef_q <= 1'b1;
        end else if (cur_nx == st) begin
          busy <= 1'b0;
        end else if (steps == LAST_STEP) begin
          busy  <= 1'b0;
          cyc_q <= 1'b1;
        end else begin
          st    <= cur_nx;
          steps <= steps + 1'b1;
        end
      end
    end
  end

  assign state_o = st;
  assign busy_o  = busy;
  assign undef_o = undef_q;
  assign cycle_o = cyc_q;

  AST_UNDEF_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n) undef_q |-> $stable(st)); // R9
  AST_CYCLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n) cyc_q |-> $stable(st)); // R10
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !go && !load) |=> $stable(st)); // R2
  AST_NO_GO_AND_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !(go && load)); // R6
endmodule

// File: rtl/ssm_switch_tbl.sv
module ssm_switch_tbl #(
  parameter int M  = 2,
  parameter int N  = 4,
  parameter int MW = 1,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [MW-1:0] wr_src_m,
  input  logic [SW-1:0] wr_src_s,
  input  logic [MW-1:0] wr_dst_m,
  input  logic [SW-1:0] wr_dst_s,
  input  logic          wr_ok,
  input  logic [MW-1:0] rd_src_m,
  input  logic [SW-1:0] rd_src_s,
  input  logic [MW-1:0] rd_dst_m,
  output logic          rd_ok,
  output logic [SW-1:0] rd_q
);
  logic          lnk_ok [M][N][M];
  logic [SW-1:0] lnk_q  [M][N][M];
  logic          wr_in_rng, rd_in_rng;

  assign wr_in_rng = int'(wr_src_m) < M && int'(wr_dst_m) < M &&
                     int'(wr_src_s) < N && int'(wr_dst_s) < N;
  assign rd_in_rng = int'(rd_src_m) < M && int'(rd_dst_m) < M && int'(rd_src_s) < N;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < M; a++) begin
        for (int s = 0; s < N; s++) begin
          for (int b = 0; b < M; b++) begin
            lnk_ok[a][s][b] <= 1'b0;
            lnk_q[a][s][b]  <= '0;
          end
        end
      end
    end else if (wr_en && wr_in_rng) begin
      lnk_ok[wr_src_m][wr_src_s][wr_dst_m] <= wr_ok;
      lnk_q[wr_src_m][wr_src_s][wr_dst_m]  <= wr_dst_s;
    end
  end

  assign rd_ok = rd_in_rng && lnk_ok[rd_src_m][rd_src_s][rd_dst_m];
  assign rd_q  = lnk_q[rd_src_m][rd_src_s][rd_dst_m];
endmodule

// File: rtl/ssm_bank.sv
module ssm_bank
  import ssm_pkg::*;
#(
  parameter int M     = 2,
  parameter int N     = 4,
  parameter int NNORM = 3,
  parameter int NADV  = 2,
  localparam int NIN  = NNORM + NADV,
  localparam int SW   = (N > 1) ? $clog2(N) : 1,
  localparam int IW   = (NIN > 1) ? $clog2(NIN) : 1,
  localparam int MW   = (M > 1) ? $clog2(M) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [MW-1:0] tbl_mach,
  input  logic [SW-1:0] tbl_state,
  input  logic [IW-1:0] tbl_in,
  input  logic [SW-1:0] tbl_next,
  input  logic          tbl_ok,
  input  logic          sw_we,
  input  logic [MW-1:0] sw_src_mach,
  input  logic [SW-1:0] sw_src_state,
  input  logic [MW-1:0] sw_dst_mach,
  input  logic [SW-1:0] sw_dst_state,
  input  logic          sw_ok,
  input  logic          in_we,
  input  logic [IW-1:0] in_code,
  input  logic          adv_we,
  input  logic [IW-1:0] adv_code,
  input  logic          sel_we,
  input  logic [MW-1:0] sel_code,
  output logic [SW-1:0] state_o,
  output logic [MW-1:0] active_o,
  output logic          stable_o,
  output logic          rej_o,
  output logic [1:0]    rej_why_o,
  output logic          flt_undef_o,
  output logic          flt_cycle_o
);
  logic [MW-1:0] active_q;
  logic [IW-1:0] cur_in_q;
  logic          rej_q;
  rej_e          why_q;

  logic [M-1:0]  busy_v, undef_v, cyc_v, mrd_ok;
  logic [SW-1:0] st_v   [M];
  logic [SW-1:0] mrd_nx [M];

  logic          lnk_ok;
  logic [SW-1:0] lnk_q;
  logic          ready;
  logic [1:0]    n_cmd;
  logic          acc_go, acc_sel, rej_n;
  rej_e          why_n;
  logic [IW-1:0] new_in, mach_in;

  assign ready = !busy_v[active_q];
  assign n_cmd = 2'($countones({in_we, adv_we, sel_we}));

  // command gate: fundamental-mode admission and switch qualification
  always_comb begin
    acc_go  = 1'b0;
    acc_sel = 1'b0;
    rej_n   = 1'b0;
    why_n   = REJ_BUSY;
    new_in  = cur_in_q;
    if (n_cmd > 2'd1) begin
      rej_n = 1'b1;
      why_n = REJ_MULTI;
    end else if (n_cmd == 2'd1 && !ready) begin
      rej_n = 1'b1;
      why_n = REJ_BUSY;
    end else if (in_we) begin
      if (int'(in_code) < NNORM) begin
        acc_go = 1'b1;
        new_in = in_code;
      end else begin
        rej_n = 1'b1;
        why_n = REJ_RANGE;
      end
    end else if (adv_we) begin
      if (int'(adv_code) < NADV) begin
        acc_go = 1'b1;
        new_in = IW'(NNORM) + adv_code;
      end else begin
        rej_n = 1'b1;
        why_n = REJ_RANGE;
      end
    end else if (sel_we) begin
      if (int'(sel_code) >= M) begin
        rej_n = 1'b1;
        why_n = REJ_RANGE;
      end else if (sel_code != active_q) begin
        if (lnk_ok && int'(cur_in_q) < NNORM &&
            mrd_ok[sel_code] && mrd_nx[sel_code] == lnk_q) begin
          acc_sel = 1'b1;
        end else begin
          rej_n = 1'b1;
          why_n = REJ_DENY;
        end
      end
    end
  end

  assign mach_in = acc_go ? new_in : cur_in_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
      cur_in_q <= '0;
      rej_q    <= 1'b0;
      why_q    <= REJ_BUSY;
    end else begin
      rej_q <= rej_n;
      why_q <= why_n;
      if (acc_go)  cur_in_q <= new_in;
      if (acc_sel) active_q <= sel_code;
    end
  end

  ssm_switch_tbl #(.M(M), .N(N), .MW(MW), .SW(SW)) u_lnk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sw_we),
    .wr_src_m (sw_src_mach),
    .wr_src_s (sw_src_state),
    .wr_dst_m (sw_dst_mach),
    .wr_dst_s (sw_dst_state),
    .wr_ok    (sw_ok),
    .rd_src_m (active_q),
    .rd_src_s (st_v[active_q]),
    .rd_dst_m (sel_code),
    .rd_ok    (lnk_ok),
    .rd_q     (lnk_q)
  );

  // demultiplexer: only the addressed machine sees go, load or a table write
  for (genvar k = 0; k < M; k++) begin : g_mach
    ssm_machine #(.N(N), .NIN(NIN), .SW(SW), .IW(IW)) u_m (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (tbl_we && tbl_mach == MW'(k)),
      .wr_state   (tbl_state),
      .wr_in      (tbl_in),
      .wr_next    (tbl_next),
      .wr_ok      (tbl_ok),
      .go         (acc_go && active_q == MW'(k)),
      .go_in      (mach_in),
      .load       (acc_sel && sel_code == MW'(k)),
      .load_state (lnk_q),
      .rd_state   (lnk_q),
      .rd_in      (cur_in_q),
      .rd_ok      (mrd_ok[k]),
      .rd_next    (mrd_nx[k]),
      .state_o    (st_v[k]),
      .busy_o     (busy_v[k]),
      .undef_o    (undef_v[k]),
      .cycle_o    (cyc_v[k])
    );
  end

  // multiplexer: feedback from the active machine
  assign state_o     = st_v[active_q];
  assign active_o    = active_q;
  assign stable_o    = ready;
  assign rej_o       = rej_q;
  assign rej_why_o   = why_q;
  assign flt_undef_o = |undef_v;
  assign flt_cycle_o = |cyc_v;

  AST_REJ_KEEPS_INPUT: assert property (@(posedge clk) disable iff (!rst_n) rej_q |-> $stable(cur_in_q)); // R3
  AST_REJ_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) rej_q |-> $stable(active_q)); // R7
  AST_SWITCH_LANDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (active_q != $past(active_q)) |-> stable_o); // R6
  AST_ONLY_ACTIVE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(busy_v) && (busy_v == '0 || busy_v[active_q])); // R2
  AST_FAULT_ENDS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n) (flt_undef_o || flt_cycle_o) |-> stable_o); // R9
endmodule

// File: tb/tb_ssm_bank.sv
module tb_ssm_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tbl_we, tbl_ok, sw_we, sw_ok, in_we, adv_we, sel_we;
  logic [0:0] tbl_mach, sw_src_mach, sw_dst_mach, sel_code;
  logic [1:0] tbl_state, tbl_next, sw_src_state, sw_dst_state;
  logic [2:0] tbl_in, in_code, adv_code;
  logic [1:0] state_o, rej_why_o;
  logic [0:0] active_o;
  logic       stable_o, rej_o, flt_undef_o, flt_cycle_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ssm_bank dut (
    .clk(clk), .rst_n(rst_n),
    .tbl_we(tbl_we), .tbl_mach(tbl_mach), .tbl_state(tbl_state), .tbl_in(tbl_in),
    .tbl_next(tbl_next), .tbl_ok(tbl_ok),
    .sw_we(sw_we), .sw_src_mach(sw_src_mach), .sw_src_state(sw_src_state),
    .sw_dst_mach(sw_dst_mach), .sw_dst_state(sw_dst_state), .sw_ok(sw_ok),
    .in_we(in_we), .in_code(in_code), .adv_we(adv_we), .adv_code(adv_code),
    .sel_we(sel_we), .sel_code(sel_code),
    .state_o(state_o), .active_o(active_o), .stable_o(stable_o),
    .rej_o(rej_o), .rej_why_o(rej_why_o),
    .flt_undef_o(flt_undef_o), .flt_cycle_o(flt_cycle_o)
  );

  // vector: {kind[15:14] 0 in/1 adv/2 sel, code[13:11], rej[10], why[9:8],
  //          state[7:6], active[5], settle cycles[4:2], fault[1:0] 0 none/1 undef/2 cycle}
  localparam logic [15:0] VEC [16] = '{
    {2'd0, 3'd0, 1'b0, 2'd0, 2'd2, 1'b0, 3'd2, 2'd0},
    {2'd2, 3'd1, 1'b0, 2'd0, 2'd1, 1'b1, 3'd0, 2'd0},
    {2'd0, 3'd1, 1'b0, 2'd0, 2'd3, 1'b1, 3'd2, 2'd0},
    {2'd2, 3'd0, 1'b1, 2'd3, 2'd3, 1'b1, 3'd0, 2'd0},
    {2'd0, 3'd0, 1'b0, 2'd0, 2'd3, 1'b1, 3'd1, 2'd1},
    {2'd2, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 2'd0},
    {2'd0, 3'd2, 1'b0, 2'd0, 2'd1, 1'b0, 3'd4, 2'd2},
    {2'd0, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 3'd2, 2'd0},
    {2'd1, 3'd0, 1'b0, 2'd0, 2'd3, 1'b0, 3'd2, 2'd0},
    {2'd2, 3'd1, 1'b1, 2'd3, 2'd3, 1'b0, 3'd0, 2'd0},
    {2'd0, 3'd1, 1'b0, 2'd0, 2'd3, 1'b0, 3'd1, 2'd0},
    {2'd2, 3'd1, 1'b0, 2'd0, 2'd3, 1'b1, 3'd0, 2'd0},
    {2'd2, 3'd1, 1'b0, 2'd0, 2'd3, 1'b1, 3'd0, 2'd0},
    {2'd0, 3'd3, 1'b1, 2'd2, 2'd3, 1'b1, 3'd0, 2'd0},
    {2'd1, 3'd1, 1'b0, 2'd0, 2'd3, 1'b1, 3'd1, 2'd1},
    {2'd1, 3'd2, 1'b1, 2'd2, 2'd3, 1'b1, 3'd0, 2'd0}
  };

  function automatic string vtag(int k);
    case (k)
      1, 5:    return "R6";
      3:       return "R7";
      4, 14:   return "R9";
      6:       return "R10";
      8, 9, 11: return "R8";
      12:      return "R11";
      13, 15:  return "R5";
      default: return "R2";
    endcase
  endfunction

  // next-state tables: {valid, next}; inputs a=0 b=1 c=2, w0=3 w1=4
  function automatic logic [2:0] tent(int m, int s, int i);
    case (m * 100 + s * 10 + i)
      0, 10:                return 3'b100;
      20, 30:               return 3'b110;
      1:                    return 3'b101;
      11:                   return 3'b110;
      21, 31:               return 3'b111;
      2:                    return 3'b101;
      12:                   return 3'b100;
      32:                   return 3'b111;
      3, 23, 33:            return 3'b111;
      100:                  return 3'b100;
      110, 120:             return 3'b101;
      101, 111, 131:        return 3'b111;
      121:                  return 3'b110;
      104, 114, 124:        return 3'b110;
      default:              return 3'b000;
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sw_put(input int sm, input int ss, input int dm, input int ds);
    sw_we = 1'b1; sw_ok = 1'b1;
    sw_src_mach = 1'(sm); sw_src_state = 2'(ss);
    sw_dst_mach = 1'(dm); sw_dst_state = 2'(ds);
    step();
    sw_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    {tbl_we, tbl_ok, sw_we, sw_ok, in_we, adv_we, sel_we} = '0;
    {tbl_mach, sw_src_mach, sw_dst_mach, sel_code} = '0;
    {tbl_state, tbl_next, sw_src_state, sw_dst_state} = '0;
    {tbl_in, in_code, adv_code} = '0;
    do_reset();

    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 active", active_o, 0);
    chk("R1 stable", stable_o, 1);
    chk("R1 pulses", {rej_o, flt_undef_o, flt_cycle_o}, 0);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 5; i++) begin
          logic [2:0] e;
          e = tent(m, s, i);
          tbl_we = 1'b1; tbl_mach = 1'(m); tbl_state = 2'(s); tbl_in = 3'(i);
          tbl_ok = e[2]; tbl_next = e[1:0];
          step();
        end
      end
    end
    tbl_we = 1'b0;
    sw_put(0, 2, 1, 1);
    sw_put(0, 0, 1, 0);
    sw_put(1, 1, 0, 2);
    sw_put(1, 3, 0, 0);
    sw_put(0, 3, 1, 3);

    // R2 three-move chain with visible intermediate states; R3 mid-chain command
    in_we = 1'b1; in_code = 3'd1;
    step();
    in_we = 1'b0;
    chk("R2 stable low after accept", stable_o, 0);
    chk("R2 state before first move", state_o, 0);
    step();
    chk("R2 first move", state_o, 1);
    in_we = 1'b1; in_code = 3'd0;
    step();
    in_we = 1'b0;
    chk("R3 rej pulse", rej_o, 1);
    chk("R3 rej reason busy", rej_why_o, 0);
    chk("R2 second move", state_o, 2);
    step();
    chk("R2 third move", state_o, 3);
    chk("R2 still unstable", stable_o, 0);
    step();
    chk("R2 settled", stable_o, 1);
    chk("R3 chain result unchanged", state_o, 3);

    // R4 collision
    in_we = 1'b1; in_code = 3'd0; sel_we = 1'b1; sel_code = 1'b1;
    step();
    in_we = 1'b0; sel_we = 1'b0;
    chk("R4 rej pulse", rej_o, 1);
    chk("R4 rej reason multi", rej_why_o, 1);
    chk("R4 active unchanged", active_o, 0);
    chk("R4 no chain started", stable_o, 1);
    chk("R4 state unchanged", state_o, 3);

    // vector walk
    for (int k = 0; k < 16; k++) begin
      logic [15:0] v;
      int n;
      v = VEC[k];
      case (v[15:14])
        2'd0: begin in_we = 1'b1; in_code = v[13:11]; end
        2'd1: begin adv_we = 1'b1; adv_code = v[13:11]; end
        default: begin sel_we = 1'b1; sel_code = v[11]; end
      endcase
      step();
      {in_we, adv_we, sel_we} = '0;
      chk(vtag(k), rej_o, int'(v[10]));
      if (v[10]) chk(vtag(k), rej_why_o, int'(v[9:8]));
      n = 0;
      while (!stable_o && n < 10) begin
        step();
        n++;
      end
      chk(vtag(k), n, int'(v[4:2]));
      chk(vtag(k), state_o, int'(v[7:6]));
      chk(vtag(k), active_o, int'(v[5]));
      chk(vtag(k), flt_undef_o, int'(v[1:0] == 2'd1));
      chk(vtag(k), flt_cycle_o, int'(v[1:0] == 2'd2));
    end

    // R1 reset in mid-run returns to the initial configuration
    do_reset();
    chk("R1 state after rerun reset", state_o, 0);
    chk("R1 active after rerun reset", active_o, 0);
    chk("R1 stable after rerun reset", stable_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule